// File: doc/BRIEF.md
# Multi-Client Memory Power Vote Aggregator

This block merges power requests from several clients that share one memory bank into a single bank power state. A client issues a vote by pulsing a strobe with its client number and the state it wants: on, retention or off. For every client the block keeps two saturating counters, one for on requests and one for retention requests. How a vote changes them depends on the bank state that is currently resolved. A vote can add to a counter, remove from one, or move a client's hold from one counter to the other.

After each vote the block resolves the bank state again over all clients. Any non-zero on counter gives on. Otherwise any non-zero retention counter gives retention. Otherwise the bank is off. The new state and a completion pulse appear together one cycle after the strobe. A decrement of a counter that is already at zero is dropped, and it sets a sticky error flag.

Top module: `pwr_vote_agg`

## Requirements
- R1: After reset all counters are zero, `bank_state` is off (3'h4), and `vote_done` and `cnt_err` are 0.
- R2: State codes on `vote_req` and `bank_state` are on = 3'h0, off = 3'h4 and retention = 3'h6. Any other request code is handled as an off request.
- R3: While the bank is off, only an on request has an effect: it increments the voting client's on counter. Retention and off requests leave the state off and do not set `cnt_err`.
- R4: While the bank is on, an off request decrements the client's on counter. A retention request increments the client's retention counter and decrements its on counter. An on request has no effect.
- R5: While the bank is in retention, an off request decrements the client's retention counter. An on request increments the client's on counter and decrements its retention counter.
- R6: The resolved state is on if any on counter is non-zero. Otherwise it is retention if any retention counter is non-zero. Otherwise it is off.
- R7: A counter at its maximum (2^CNT_W-1) ignores an increment and does not wrap.
- R8: A decrement of a counter at zero leaves it at zero and sets `cnt_err`. `cnt_err` stays set until reset.
- R9: `bank_state` takes its new value and `vote_done` is high in the cycle after a strobe. `vote_done` is high for exactly one cycle per strobe. Without a strobe, `bank_state` holds its value.
- R10: Each client's counters change only on that client's votes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vote_valid | input | 1 | Vote strobe, one cycle per vote |
| vote_client | input | ID_W | Number of the voting client |
| vote_req | input | 3 | Requested state code |
| bank_state | output | 3 | Resolved bank state code |
| vote_done | output | 1 | Pulse one cycle after each vote |
| cnt_err | output | 1 | Sticky flag for a decrement at zero |

## Verification
The hardest case to reach is counter saturation. Under these rules an on counter cannot rise above one: it only counts up while the bank is off or in retention, and in those states every on counter is already zero. A retention counter can climb only while some other client holds the bank on. The stimulus therefore has one client vote on, then sends seventeen retention votes from a second client, and then counts the off votes the second client needs to bring the bank back to off. If the counter wrapped, the bank would reach off far too early.

// File: rtl/pvote_pkg.sv
package pvote_pkg;

  typedef enum logic [2:0] {
    PWR_ON  = 3'h0,
    PWR_OFF = 3'h4,
    PWR_RET = 3'h6
  } pwr_e;

  // Request code to state; unknown codes are taken as an off request.
  function automatic pwr_e f_req_decode(input logic [2:0] code);
    case (code)
      3'h0:    f_req_decode = PWR_ON;
      3'h6:    f_req_decode = PWR_RET;
      default: f_req_decode = PWR_OFF;
    endcase
  endfunction

  // Priority: on beats retention, retention beats off.
  function automatic pwr_e f_pick(input logic any_on, input logic any_ret);
    if (any_on)       f_pick = PWR_ON;
    else if (any_ret) f_pick = PWR_RET;
    else              f_pick = PWR_OFF;
  endfunction

endpackage

// File: rtl/pvote_slot.sv
module pvote_slot
  import pvote_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  pwr_e req,
  input  pwr_e cur,
  output logic on_nz,
  output logic ret_nz,
  output logic on_nz_nxt,
  output logic ret_nz_nxt,
  output logic underflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] f_step(input logic [CNT_W-1:0] q,
                                              input logic up, input logic dn);
    if (up && q != CNT_MAX)  f_step = q + 1'b1;
    else if (dn && q != '0)  f_step = q - 1'b1;
    else                     f_step = q;
  endfunction

  logic [CNT_W-1:0] on_q, ret_q, on_d, ret_d;
  logic on_inc, on_dec, ret_inc, ret_dec;

  // Counter events, chosen from the current resolved state.
  always_comb begin
    on_inc = 1'b0; on_dec = 1'b0; ret_inc = 1'b0; ret_dec = 1'b0;
    if (hit) begin
      case (cur)
        PWR_OFF: on_inc = (req == PWR_ON);
        PWR_ON: begin
          if (req == PWR_OFF) on_dec = 1'b1;
          else if (req == PWR_RET) begin ret_inc = 1'b1; on_dec = 1'b1; end
        end
        PWR_RET: begin
          if (req == PWR_OFF) ret_dec = 1'b1;
          else if (req == PWR_ON) begin on_inc = 1'b1; ret_dec = 1'b1; end
        end
        default: ;
      endcase
    end
  end

  assign on_d       = f_step(on_q, on_inc, on_dec);
  assign ret_d      = f_step(ret_q, ret_inc, ret_dec);
  assign underflow  = (on_dec && on_q == '0) || (ret_dec && ret_q == '0);
  assign on_nz      = (on_q != '0);
  assign ret_nz     = (ret_q != '0);
  assign on_nz_nxt  = (on_d != '0);
  assign ret_nz_nxt = (ret_d != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q  <= '0;
      ret_q <= '0;
    end else begin
      on_q  <= on_d;
      ret_q <= ret_d;
    end
  end

  a_r7_ret_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_inc && ret_q == CNT_MAX) |=> (ret_q == CNT_MAX));
  a_r7_on_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (on_inc && on_q == CNT_MAX) |=> (on_q == CNT_MAX));
  a_r8_ret_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_dec && ret_q == '0) |=> (ret_q == '0));
  a_r10_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(on_q) && $stable(ret_q)));

endmodule

// File: rtl/pvote_resolve.sv
module pvote_resolve
  import pvote_pkg::*;
#(
  parameter int N_CLIENTS = 4
) (
  input  logic [N_CLIENTS-1:0] on_nz,
  input  logic [N_CLIENTS-1:0] ret_nz,
  output pwr_e                 state
);
  logic any_on, any_ret;

  always_comb begin
    any_on  = 1'b0;
    any_ret = 1'b0;
    for (int i = 0; i < N_CLIENTS; i++) begin
      any_on  = any_on  | on_nz[i];
      any_ret = any_ret | ret_nz[i];
    end
  end

  assign state = f_pick(any_on, any_ret);

endmodule

// File: rtl/pwr_vote_agg.sv
module pwr_vote_agg
  import pvote_pkg::*;
#(
  parameter int N_CLIENTS = 4,
  parameter int CNT_W     = 4,
  localparam int ID_W     = (N_CLIENTS > 1) ? $clog2(N_CLIENTS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vote_valid,
  input  logic [ID_W-1:0] vote_client,
  input  logic [2:0]      vote_req,
  output logic [2:0]      bank_state,
  output logic            vote_done,
  output logic            cnt_err
);
  pwr_e                 state_q, state_d, req_dec;
  logic                 done_q, err_q;
  logic [N_CLIENTS-1:0] hit, on_nz, ret_nz, on_nz_nxt, ret_nz_nxt, uflow;

  assign req_dec = f_req_decode(vote_req);

  for (genvar g = 0; g < N_CLIENTS; g++) begin : g_slot
    assign hit[g] = vote_valid && (vote_client == ID_W'(g));
    pvote_slot #(.CNT_W(CNT_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit        (hit[g]),
      .req        (req_dec),
      .cur        (state_q),
      .on_nz      (on_nz[g]),
      .ret_nz     (ret_nz[g]),
      .on_nz_nxt  (on_nz_nxt[g]),
      .ret_nz_nxt (ret_nz_nxt[g]),
      .underflow  (uflow[g])
    );
  end

  pvote_resolve #(.N_CLIENTS(N_CLIENTS)) u_resolve (
    .on_nz  (on_nz_nxt),
    .ret_nz (ret_nz_nxt),
    .state  (state_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PWR_OFF;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= vote_valid;
      err_q  <= err_q | (|uflow);
      if (vote_valid) state_q <= state_d;
    end
  end

  assign bank_state = state_q;
  assign vote_done  = done_q;
  assign cnt_err    = err_q;

  a_r6_on_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|on_nz) |-> (state_q == PWR_ON));
  a_r6_ret_second: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|on_nz) && (|ret_nz)) |-> (state_q == PWR_RET));
  a_r6_off_last: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|on_nz) && !(|ret_nz)) |-> (state_q == PWR_OFF));
  a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    vote_valid |=> vote_done);
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !vote_valid |=> !vote_done);
  a_r9_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vote_valid |=> $stable(bank_state));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_err |=> cnt_err);
  a_r10_one_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

endmodule

// File: tb/pwr_vote_agg_tb.sv
`timescale 1ns/1ps
module pwr_vote_agg_tb;
  localparam int NC = 4;
  localparam int IW = 2;
  localparam logic [2:0] S_ON = 3'h0, S_OFF = 3'h4, S_RET = 3'h6;

  logic clk = 1'b0, rst_n = 1'b0, vote_valid = 1'b0;
  logic [IW-1:0] vote_client = '0;
  logic [2:0] vote_req = 3'h4, bank_state;
  logic vote_done, cnt_err;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  pwr_vote_agg #(.N_CLIENTS(NC), .CNT_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .vote_valid(vote_valid), .vote_client(vote_client),
    .vote_req(vote_req), .bank_state(bank_state), .vote_done(vote_done), .cnt_err(cnt_err)
  );

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; vote_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Called at a negedge; strobe lasts one cycle, result sampled next negedge.
  task automatic vote(input int c, input logic [2:0] req, input logic [2:0] exp, input string tag);
    vote_valid = 1'b1; vote_client = IW'(c); vote_req = req;
    @(negedge clk);
    vote_valid = 1'b0;
    chk({tag, " state"}, bank_state, exp);
    chk("R9 done pulse", {2'b0, vote_done}, 3'h1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset state", bank_state, S_OFF);
    chk("R1 reset done", {2'b0, vote_done}, 3'h0);
    chk("R1 reset err", {2'b0, cnt_err}, 3'h0);
  endtask

  task automatic t_off_filter();
    do_reset();
    vote(0, S_RET, S_OFF, "R3 ret while off");
    vote(0, S_OFF, S_OFF, "R3 off while off");
    chk("R3 no err", {2'b0, cnt_err}, 3'h0);
    vote(0, S_ON, S_ON, "R3 on while off");
    vote(0, S_OFF, S_OFF, "R4 off drops on");
    chk("R3 err clear", {2'b0, cnt_err}, 3'h0);
  endtask

  task automatic t_moves();
    do_reset();
    vote(0, S_ON,  S_ON,  "R4 first on");
    vote(0, S_RET, S_RET, "R4 on to ret");
    vote(0, S_ON,  S_ON,  "R5 ret to on");
    vote(0, S_OFF, S_OFF, "R4 on to off");
    vote(0, S_ON,  S_ON,  "R4 on again");
    vote(0, S_RET, S_RET, "R4 move again");
    vote(0, S_OFF, S_OFF, "R5 ret to off");
    chk("R5 no err", {2'b0, cnt_err}, 3'h0);
  endtask

  task automatic t_codes();
    do_reset();
    vote(2, S_ON, S_ON,  "R2 on code");
    vote(2, 3'h1, S_OFF, "R2 code 1 as off");
    vote(2, S_ON, S_ON,  "R2 on code again");
    vote(2, 3'h7, S_OFF, "R2 code 7 as off");
    chk("R2 no err", {2'b0, cnt_err}, 3'h0);
  endtask

  task automatic t_clients();
    do_reset();
    vote(0, S_ON,  S_ON,  "R10 c0 on");
    vote(1, S_ON,  S_ON,  "R4 c1 on ignored");
    vote(0, S_OFF, S_OFF, "R10 c0 off");
    vote(0, S_ON,  S_ON,  "R10 c0 on again");
    vote(1, S_RET, S_ON,  "R6 on beats ret");
    chk("R8 err set", {2'b0, cnt_err}, 3'h1);
    vote(0, S_RET, S_RET, "R6 ret second");
    vote(0, S_OFF, S_RET, "R10 c1 still holds");
    vote(1, S_OFF, S_OFF, "R6 off last");
    repeat (3) @(negedge clk);
    chk("R8 err sticky", {2'b0, cnt_err}, 3'h1);
    chk("R9 done low idle", {2'b0, vote_done}, 3'h0);
    chk("R9 state held", bank_state, S_OFF);
    do_reset();
    chk("R8 err cleared by reset", {2'b0, cnt_err}, 3'h0);
  endtask

  task automatic t_saturate();
    do_reset();
    vote(3, S_ON, S_ON, "R7 c3 on");
    for (int k = 0; k < 17; k++) vote(2, S_RET, S_ON, "R7 c2 ret");
    vote(3, S_OFF, S_RET, "R7 c3 off");
    for (int k = 0; k < 14; k++) vote(2, S_OFF, S_RET, "R7 drain");
    vote(2, S_OFF, S_OFF, "R7 fifteenth drain");
    vote(2, S_OFF, S_OFF, "R8 extra drain");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_off_filter();
    t_moves();
    t_codes();
    t_clients();
    t_saturate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule